// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits behind the transaction layer of a PCIe root port. It watches a simple inbound memory-write channel. When a write lands on the programmed 64-bit target address, the low bits of the write data are taken as a vector number, and the matching status bit in a bank of grouped registers is set. Software enables vectors one group at a time. It acknowledges them by writing back the status value it read, because status bits are write-one-to-clear.

All enabled pending vectors are merged into one request. That request sets a wrapper-level pending flag. The flag is acknowledged the same way and is gated by its own enable bit. The gated flag drives a single level interrupt line towards the host interrupt controller. The register port is a plain synchronous write strobe with a combinational read mux. All offsets are byte addresses, and an offset that is not decoded reads as zero and ignores writes.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, every status, enable, target-address and wrapper register reads zero, and `irqOut` is low.
- R2: A write on the MSI channel whose 64-bit address equals the target and whose data value is below 256 sets status bit (data mod 32) of group (data / 32) at the next clock edge, whether or not that vector is enabled.
- R3: An MSI write whose address differs from the target in any bit, including the high word, changes no status bit.
- R4: An MSI write carrying a data value of 256 or more changes no status bit.
- R5: Writing to a group status register (offset group×12) clears each status bit written as one and leaves bits written as zero unchanged.
- R6: Group g has its status register at byte offset g×12 and its read/write enable register at g×12+4. Offset g×12+8 reads zero.
- R7: The target address low word is at offset 0x60 and the high word at 0x64. With the high word at zero, a 32-bit address matches.
- R8: The wrapper pending register (offset 0x68) has its bit 2 set at the clock edge after any group holds a bit that is both pending and enabled. Writing one to bit 2 clears it, unless the merged request is still present at that edge. Its other bits read zero.
- R9: `irqOut` equals wrapper pending bit 2 AND wrapper enable bit 2 (offset 0x6C, the only bit stored there). It rises two edges after the capturing MSI write when both enables are already set.
- R10: When an MSI write and a status clear hit the same bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msiWrValid | input | 1 | Inbound memory write present this cycle |
| msiWrAddr | input | 64 | Inbound write address |
| msiWrData | input | 32 | Inbound write data (vector number) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
The hardest case to reach is the race at a single edge. An inbound write sets a bit while software's write-one-to-clear removes the same bit. A related race is the wrapper pending clear arriving while the merged request is still present. Directed steps drive the MSI channel and the register port in the same cycle on the same vector, and then read the status back. A random phase with a fixed seed then mixes matching, mismatching and out-of-range writes with register writes aimed at the decoded offsets, so these collisions also arise on their own. Each cycle, `irqOut` and a readback are compared against a cycle-level model in the bench.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int NUM_GROUPS    = 8;
  localparam int DATA_W        = 32;
  localparam int VEC_PER_GROUP = DATA_W;
  localparam int NUM_VEC       = NUM_GROUPS * VEC_PER_GROUP;
  localparam int GRP_W         = $clog2(NUM_GROUPS);
  localparam int BIT_W         = $clog2(VEC_PER_GROUP);
  localparam int IDX_W         = $clog2(NUM_VEC);
  localparam int ADDR_W        = 64;
  localparam int REG_AW        = 8;
  localparam int GROUP_STRIDE  = 12;
  localparam int GRP_SPAN      = NUM_GROUPS * GROUP_STRIDE;
  localparam int OFF_TGT_LO    = GRP_SPAN;
  localparam int OFF_TGT_HI    = GRP_SPAN + 4;
  localparam int OFF_WPEND     = GRP_SPAN + 8;
  localparam int OFF_WEN       = GRP_SPAN + 12;
  localparam int MSI_SRC_BIT   = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_STAT, RD_EN, RD_TLO, RD_THI, RD_PEND, RD_WEN
  } rdSel_t;

  typedef struct packed {
    logic             msiSet;
    logic [GRP_W-1:0] msiGrp;
    logic [BIT_W-1:0] msiBit;
    logic [GRP_W-1:0] regGrp;
    rdSel_t           rdSel;
    logic             statW1c;
    logic             enWr;
    logic             tgtLoWr;
    logic             tgtHiWr;
    logic             pendW1c;
    logic             wrapEnWr;
  } ctrlStrb_t;
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
(
  input  logic              msiWrValid,
  input  logic [ADDR_W-1:0] msiWrAddr,
  input  logic [DATA_W-1:0] msiWrData,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] tgtAddr,
  output ctrlStrb_t         strb
);
  logic [REG_AW-1:0] quo, rem;
  rdSel_t sel;

  always_comb begin
    quo = regAddr / REG_AW'(GROUP_STRIDE);
    rem = regAddr % REG_AW'(GROUP_STRIDE);
    sel = RD_NONE;
    if (regAddr < REG_AW'(GRP_SPAN)) begin
      if (rem == REG_AW'(0))      sel = RD_STAT;
      else if (rem == REG_AW'(4)) sel = RD_EN;
    end else if (regAddr == REG_AW'(OFF_TGT_LO)) sel = RD_TLO;
    else if (regAddr == REG_AW'(OFF_TGT_HI))     sel = RD_THI;
    else if (regAddr == REG_AW'(OFF_WPEND))      sel = RD_PEND;
    else if (regAddr == REG_AW'(OFF_WEN))        sel = RD_WEN;
  end

  always_comb begin
    strb          = '0;
    strb.msiSet   = msiWrValid && (msiWrAddr == tgtAddr) &&
                    (msiWrData < DATA_W'(NUM_VEC));
    strb.msiGrp   = msiWrData[BIT_W +: GRP_W];
    strb.msiBit   = msiWrData[BIT_W-1:0];
    strb.regGrp   = quo[GRP_W-1:0];
    strb.rdSel    = sel;
    strb.statW1c  = regWrEn && (sel == RD_STAT);
    strb.enWr     = regWrEn && (sel == RD_EN);
    strb.tgtLoWr  = regWrEn && (sel == RD_TLO);
    strb.tgtHiWr  = regWrEn && (sel == RD_THI);
    strb.pendW1c  = regWrEn && (sel == RD_PEND);
    strb.wrapEnWr = regWrEn && (sel == RD_WEN);
  end
endmodule

// File: rtl/msi_cap_datapath.sv
module msi_cap_datapath
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [NUM_GROUPS-1:0][VEC_PER_GROUP-1:0] statusQ;
  logic [NUM_GROUPS-1:0][VEC_PER_GROUP-1:0] enableQ;
  logic [NUM_GROUPS-1:0] groupHit;
  logic [DATA_W-1:0] tgtLoQ, tgtHiQ;
  logic pendQ, wrapEnQ, anyHit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [VEC_PER_GROUP-1:0] setMask, clrMask;
    always_comb begin
      setMask = '0;
      if (strb.msiSet && strb.msiGrp == GRP_W'(g)) setMask[strb.msiBit] = 1'b1;
      clrMask = (strb.statW1c && strb.regGrp == GRP_W'(g)) ? regWrData : '0;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[g] <= '0;
        enableQ[g] <= '0;
      end else begin
        statusQ[g] <= (statusQ[g] & ~clrMask) | setMask;
        if (strb.enWr && strb.regGrp == GRP_W'(g)) enableQ[g] <= regWrData;
      end
    end
    assign groupHit[g] = |(statusQ[g] & enableQ[g]);
  end

  assign anyHit = |groupHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtLoQ  <= '0;
      tgtHiQ  <= '0;
      pendQ   <= 1'b0;
      wrapEnQ <= 1'b0;
    end else begin
      if (strb.tgtLoWr)  tgtLoQ  <= regWrData;
      if (strb.tgtHiWr)  tgtHiQ  <= regWrData;
      if (strb.wrapEnWr) wrapEnQ <= regWrData[MSI_SRC_BIT];
      if (anyHit)        pendQ   <= 1'b1;
      else if (strb.pendW1c && regWrData[MSI_SRC_BIT]) pendQ <= 1'b0;
    end
  end

  assign tgtAddr = {tgtHiQ, tgtLoQ};
  assign irqOut  = pendQ & wrapEnQ;

  always_comb begin
    regRdData = '0;
    case (strb.rdSel)
      RD_STAT: regRdData = statusQ[strb.regGrp];
      RD_EN:   regRdData = enableQ[strb.regGrp];
      RD_TLO:  regRdData = tgtLoQ;
      RD_THI:  regRdData = tgtHiQ;
      RD_PEND: regRdData[MSI_SRC_BIT] = pendQ;
      RD_WEN:  regRdData[MSI_SRC_BIT] = wrapEnQ;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              msiWrValid,
  input  logic [ADDR_W-1:0] msiWrAddr,
  input  logic [DATA_W-1:0] msiWrData,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] tgtAddr;

  msi_cap_ctrl u_ctrl (
    .msiWrValid(msiWrValid), .msiWrAddr(msiWrAddr), .msiWrData(msiWrData),
    .regWrEn(regWrEn), .regAddr(regAddr), .tgtAddr(tgtAddr), .strb(strb)
  );

  msi_cap_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .tgtAddr(tgtAddr), .regRdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk
  import msi_cap_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               msiWrValid,
  input logic [ADDR_W-1:0]  msiWrAddr,
  input logic [DATA_W-1:0]  msiWrData,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  tgtAddr,
  input logic [NUM_VEC-1:0] statusFlat,
  input logic [NUM_VEC-1:0] enableFlat,
  input logic               pendQ
);
  // R2 (the set also wins against a same-edge clear, R10)
  msi_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msiWrValid && msiWrAddr == tgtAddr && msiWrData < DATA_W'(NUM_VEC))
    |=> statusFlat[$past(msiWrData[IDX_W-1:0])]);

  // R3
  no_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msiWrValid && msiWrAddr != tgtAddr && !regWrEn) |=> $stable(statusFlat));

  // R4
  range_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msiWrValid && msiWrData >= DATA_W'(NUM_VEC) && !regWrEn) |=> $stable(statusFlat));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusFlat & enableFlat)) |=> pendQ);
endmodule

bind msi_capture_ctrl msi_capture_chk chk_i (
  .clk(clk), .rstN(rstN), .msiWrValid(msiWrValid), .msiWrAddr(msiWrAddr),
  .msiWrData(msiWrData), .regWrEn(regWrEn), .tgtAddr(tgtAddr),
  .statusFlat(u_dp.statusQ), .enableFlat(u_dp.enableQ), .pendQ(u_dp.pendQ)
);

// File: tb/msi_capture_ctrl_tb_top.sv
module msi_capture_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msiWrValid = 1'b0;
  logic [63:0] msiWrAddr = '0;
  logic [31:0] msiWrData = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0, failures = 0;
  logic [31:0] mStat [8];
  logic [31:0] mEn [8];
  logic [31:0] mLo, mHi;
  logic mPend, mWen;
  bit done = 0;

  always #5 clk = ~clk;

  msi_capture_ctrl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(logic [7:0] a);
    if (a < 8'd96) begin
      if (a % 12 == 0) return mStat[a / 12];
      if (a % 12 == 4) return mEn[a / 12];
      return 32'h0;
    end
    case (a)
      8'h60: return mLo;
      8'h64: return mHi;
      8'h68: return {29'h0, mPend, 2'b00};
      8'h6C: return {29'h0, mWen, 2'b00};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit mAgg();
    for (int g = 0; g < 8; g++) if ((mStat[g] & mEn[g]) != 0) return 1;
    return 0;
  endfunction

  // One clock: check readback of current state, take the edge, update model.
  task automatic tick(string req);
    bit agg, hit;
    #1 chk({req, " readback R6"}, regRdData, mRead(regAddr));
    agg = mAgg();
    hit = msiWrValid && msiWrAddr == {mHi, mLo} && msiWrData < 256;
    @(posedge clk);
    if (regWrEn) begin
      if (regAddr < 96 && regAddr % 12 == 0) mStat[regAddr / 12] &= ~regWrData;
      if (regAddr < 96 && regAddr % 12 == 4) mEn[regAddr / 12] = regWrData;
      if (regAddr == 8'h60) mLo = regWrData;
      if (regAddr == 8'h64) mHi = regWrData;
      if (regAddr == 8'h6C) mWen = regWrData[2];
      if (regAddr == 8'h68 && regWrData[2]) mPend = 0;
    end
    if (agg) mPend = 1;
    if (hit) mStat[msiWrData / 32][msiWrData % 32] = 1'b1;
    @(negedge clk);
    msiWrValid = 0; regWrEn = 0;
    chk({req, " irq R9"}, {31'h0, irqOut}, {31'h0, mPend & mWen});
  endtask

  task automatic regWr(logic [7:0] a, logic [31:0] d, string req);
    regWrEn = 1; regAddr = a; regWrData = d; tick(req);
  endtask

  task automatic msi(logic [63:0] a, logic [31:0] d, string req);
    msiWrValid = 1; msiWrAddr = a; msiWrData = d; tick(req);
  endtask

  task automatic rd(logic [7:0] a, string req);
    regAddr = a; #1 chk(req, regRdData, mRead(a));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int g = 0; g < 8; g++) begin mStat[g] = 0; mEn[g] = 0; end
    mLo = 0; mHi = 0; mPend = 0; mWen = 0;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values
    for (int a = 0; a < 112; a += 4) rd(8'(a), "R1 reset");
    chk("R1 irq", {31'h0, irqOut}, 32'h0);
    // R7 target programming, high word zero
    regWr(8'h60, 32'hFEE0_1000, "R7");
    regWr(8'h64, 32'h0, "R7");
    rd(8'h60, "R7 lo"); rd(8'h64, "R7 hi");
    // R2 capture without enable
    msi(64'hFEE0_1000, 32'd37, "R2");
    rd(8'd12, "R2 group1 status");
    chk("R2 bit5 of group1", regRdData, 32'h20);
    chk("R9 no irq while disabled", {31'h0, irqOut}, 32'h0);
    // R3 high-word mismatch, R4 out of range
    msi(64'h1_FEE0_1000, 32'd3, "R3");
    rd(8'd0, "R3 status g0");
    chk("R3 nothing set", regRdData, 32'h0);
    msi(64'hFEE0_1000, 32'd300, "R4");
    for (int g = 0; g < 8; g++) rd(8'(g * 12), "R4 no status");
    // R6 enable at +4, +8 reads zero
    regWr(8'd16, 32'h20, "R6");
    rd(8'd16, "R6 enable"); rd(8'd20, "R6 gap");
    chk("R6 gap zero", regRdData, 32'h0);
    // R8/R9 pending and gated output
    tick("R8");
    rd(8'h68, "R8 pend");
    chk("R8 pend bit2", regRdData, 32'h4);
    regWr(8'h6C, 32'h4, "R9");
    chk("R9 irq high", {31'h0, irqOut}, 32'h1);
    regWr(8'h68, 32'h4, "R8 clear while active");
    chk("R8 pend stays", {31'h0, irqOut}, 32'h1);
    // R5 W1C then pending clear
    regWr(8'd12, 32'h20, "R5");
    rd(8'd12, "R5 cleared");
    chk("R5 status zero", regRdData, 32'h0);
    tick("R8");
    regWr(8'h68, 32'h4, "R8 clear");
    chk("R8 irq low", {31'h0, irqOut}, 32'h0);
    // R10 same-edge set and clear
    msiWrValid = 1; msiWrAddr = 64'hFEE0_1000; msiWrData = 32'd37;
    regWrEn = 1; regAddr = 8'd12; regWrData = 32'hFFFF_FFFF;
    tick("R10");
    rd(8'd12, "R10 set wins");
    chk("R10 bit kept", regRdData, 32'h20);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        msiWrValid = 1;
        msiWrAddr = ($urandom_range(0, 5) == 0) ? {32'h0, $urandom()} : {mHi, mLo};
        msiWrData = ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 255));
      end
      if (op >= 3 && op < 8) begin
        regWrEn = 1;
        regAddr = ($urandom_range(0, 3) == 0) ? 8'(4 * $urandom_range(24, 27))
                                              : 8'(12 * $urandom_range(0, 7) + 4 * $urandom_range(0, 1));
        regWrData = ($urandom_range(0, 1) == 0) ? $urandom() : 32'h4;
        if (regAddr == 8'h60 || regAddr == 8'h64) regWrEn = ($urandom_range(0, 3) == 0);
      end else regAddr = 8'($urandom_range(0, 111));
      tick("R2 R5 random");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule